// File: doc/BRIEF.md
# Multiplexed Latching Bus Exchanger

The block joins one processor-side data port (A) to two bank-side data ports, an even bank (1B) and an odd bank (2B). It is used to split one multiplexed address/data stream into two banks, or to merge two banks back onto the processor side, for example when memory is interleaved. Four storage stages sit between the ports, and each has its own enable. Two of them carry A toward each bank. The other two carry each bank toward A. A bank-select input picks which of the two return stages feeds the A port.

Each stage is a clock-sampled latch. On every clock edge where its enable is high, it takes its input (transparent). On every edge where the enable is low, it keeps the last value it took (hold). The value taken on the last high-enable edge before a falling enable is therefore the captured value. All outputs are registered and follow the sampled inputs one clock later. Each bidirectional pin group is split into a data-in vector, a data-out vector and a registered "driving" flag. The flag is the inverse of the port's active-low output enable, and the pad logic outside the block uses it to switch its drivers. A synchronous active-high reset clears every stage, every output and every driving flag.

Top module: `mbx_exchanger`

## Requirements
- R1: In the clock after a clock edge where `rst` is high, `a_out`, `b1_out` and `b2_out` are all zero and `a_drive`, `b1_drive` and `b2_drive` are all 0.
- R2: On an edge where `up1_en` is 1, the A-to-even stage takes `a_in`, and `b1_out` shows that value after the edge.
- R3: On edges where a stage's enable is 0, the stage keeps its value regardless of its data input. For the A-to-bank stages, `b1_out` or `b2_out` stays unchanged.
- R4: On an edge where `up2_en` is 1, the A-to-odd stage takes `a_in`, and `b2_out` shows it after the edge. This is independent of `up1_en`: with both enables at 1, both banks receive the same A value.
- R5: The even-to-A stage (enable `dn1_en`, data `b1_in`) and the odd-to-A stage (enable `dn2_en`, data `b2_in`) take and hold their inputs independently, whether or not they are selected at the time.
- R6: After an edge, `a_out` equals the value the even-to-A stage holds after that edge when `sel_even` was 1 at the edge, and the value the odd-to-A stage holds after that edge when `sel_even` was 0.
- R7: After each edge, each driving flag equals the inverse of its active-low enable as sampled at that edge (`a_drive` = !`a_oe_n`, `b1_drive` = !`b1_oe_n`, `b2_drive` = !`b2_oe_n`). The two bank flags are independent, so neither, one or both banks may drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data arriving on the processor-side pins |
| a_out | output | WIDTH | Data to drive onto the processor-side pins |
| a_drive | output | 1 | 1 = processor-side drivers on |
| a_oe_n | input | 1 | Processor-side output enable, active low |
| b1_in | input | WIDTH | Data arriving on the even-bank pins |
| b1_out | output | WIDTH | Data to drive onto the even-bank pins |
| b1_drive | output | 1 | 1 = even-bank drivers on |
| b1_oe_n | input | 1 | Even-bank output enable, active low |
| b2_in | input | WIDTH | Data arriving on the odd-bank pins |
| b2_out | output | WIDTH | Data to drive onto the odd-bank pins |
| b2_drive | output | 1 | 1 = odd-bank drivers on |
| b2_oe_n | input | 1 | Odd-bank output enable, active low |
| up1_en | input | 1 | Enable of the A-to-even stage (1 = transparent) |
| up2_en | input | 1 | Enable of the A-to-odd stage (1 = transparent) |
| dn1_en | input | 1 | Enable of the even-to-A stage (1 = transparent) |
| dn2_en | input | 1 | Enable of the odd-to-A stage (1 = transparent) |
| sel_even | input | 1 | 1 = A shows the even return stage, 0 = the odd one |

## Verification
Two things can happen on the same edge: `sel_even` switches to a return stage, and that same stage takes a new value from its bank, or drops its enable and captures. The A port must then show the value the stage holds after the edge, not the stale one. The bench provokes this both on purpose, by flipping `sel_even` on the very edge where `dn1_en` or `dn2_en` falls with fresh bank data, and at random, by toggling `sel_even` and all four enables independently on every cycle. A bench model updates the four stage values first and then applies the select, and it judges `a_out` against that model one edge later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // index of each storage stage inside the exchanger
  localparam int STG_UP_EVEN = 0;  // A -> even bank
  localparam int STG_UP_ODD  = 1;  // A -> odd bank
  localparam int STG_DN_EVEN = 2;  // even bank -> A
  localparam int STG_DN_ODD  = 3;  // odd bank -> A
  localparam int STG_COUNT   = 4;

  // pin groups with an output enable
  localparam int GRP_A     = 0;
  localparam int GRP_EVEN  = 1;
  localparam int GRP_ODD   = 2;
  localparam int GRP_COUNT = 3;

  typedef enum logic {
    RET_ODD  = 1'b0,
    RET_EVEN = 1'b1
  } ret_src_e;
endpackage

// File: rtl/mbx_stage.sv
// Clock-sampled latch: takes d on edges where en is high, holds otherwise.
// nxt exposes the value the stage will hold after the coming edge.
module mbx_stage #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] nxt
);
  assign nxt = en ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/mbx_return_mux.sv
// Registered selection of the return stage that feeds the A port.
module mbx_return_mux #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_even,
  input  logic [WIDTH-1:0] even_nxt,
  input  logic [WIDTH-1:0] odd_nxt,
  output logic [WIDTH-1:0] y
);
  import mbx_pkg::*;

  ret_src_e src;
  assign src = ret_src_e'(sel_even);

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else begin
      case (src)
        RET_EVEN: y <= even_nxt;
        default:  y <= odd_nxt;
      endcase
    end
  end
endmodule

// File: rtl/mbx_drive_ctl.sv
// Registered driver flags, one per pin group, from active-low enables.
module mbx_drive_ctl #(
  parameter int GROUPS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GROUPS-1:0] oe_n,
  output logic [GROUPS-1:0] drive
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) drive[g] <= 1'b0;
      else     drive[g] <= ~oe_n[g];
    end
  end
endmodule

// File: rtl/mbx_exchanger.sv
module mbx_exchanger #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic             a_oe_n,
  input  logic [WIDTH-1:0] b1_in,
  output logic [WIDTH-1:0] b1_out,
  output logic             b1_drive,
  input  logic             b1_oe_n,
  input  logic [WIDTH-1:0] b2_in,
  output logic [WIDTH-1:0] b2_out,
  output logic             b2_drive,
  input  logic             b2_oe_n,
  input  logic             up1_en,
  input  logic             up2_en,
  input  logic             dn1_en,
  input  logic             dn2_en,
  input  logic             sel_even
);
  import mbx_pkg::*;

  logic [WIDTH-1:0] stg_d   [STG_COUNT];
  logic [WIDTH-1:0] stg_q   [STG_COUNT];
  logic [WIDTH-1:0] stg_nxt [STG_COUNT];
  logic [STG_COUNT-1:0] stg_en;

  assign stg_d[STG_UP_EVEN] = a_in;
  assign stg_d[STG_UP_ODD]  = a_in;
  assign stg_d[STG_DN_EVEN] = b1_in;
  assign stg_d[STG_DN_ODD]  = b2_in;

  assign stg_en[STG_UP_EVEN] = up1_en;
  assign stg_en[STG_UP_ODD]  = up2_en;
  assign stg_en[STG_DN_EVEN] = dn1_en;
  assign stg_en[STG_DN_ODD]  = dn2_en;

  for (genvar s = 0; s < STG_COUNT; s++) begin : g_stg
    mbx_stage #(.WIDTH(WIDTH)) u_stage (
      .clk (clk),
      .rst (rst),
      .en  (stg_en[s]),
      .d   (stg_d[s]),
      .q   (stg_q[s]),
      .nxt (stg_nxt[s])
    );
  end

  assign b1_out = stg_q[STG_UP_EVEN];
  assign b2_out = stg_q[STG_UP_ODD];

  mbx_return_mux #(.WIDTH(WIDTH)) u_ret (
    .clk      (clk),
    .rst      (rst),
    .sel_even (sel_even),
    .even_nxt (stg_nxt[STG_DN_EVEN]),
    .odd_nxt  (stg_nxt[STG_DN_ODD]),
    .y        (a_out)
  );

  logic [GRP_COUNT-1:0] grp_oe_n;
  logic [GRP_COUNT-1:0] grp_drive;

  assign grp_oe_n[GRP_A]    = a_oe_n;
  assign grp_oe_n[GRP_EVEN] = b1_oe_n;
  assign grp_oe_n[GRP_ODD]  = b2_oe_n;

  mbx_drive_ctl #(.GROUPS(GRP_COUNT)) u_drv (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (grp_oe_n),
    .drive (grp_drive)
  );

  assign a_drive  = grp_drive[GRP_A];
  assign b1_drive = grp_drive[GRP_EVEN];
  assign b2_drive = grp_drive[GRP_ODD];
endmodule

// File: rtl/mbx_exchanger_chk.sv
module mbx_exchanger_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic             a_oe_n,
  input logic [WIDTH-1:0] b1_in,
  input logic [WIDTH-1:0] b1_out,
  input logic             b1_drive,
  input logic             b1_oe_n,
  input logic [WIDTH-1:0] b2_in,
  input logic [WIDTH-1:0] b2_out,
  input logic             b2_drive,
  input logic             b2_oe_n,
  input logic             up1_en,
  input logic             up2_en,
  input logic             dn1_en,
  input logic             dn2_en,
  input logic             sel_even
);
  logic started;
  logic armed;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    armed   <= !rst;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    started && $past(rst) |-> (a_out == '0 && b1_out == '0 && b2_out == '0
                               && !a_drive && !b1_drive && !b2_drive));

  // R2
  up_even_pass_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(up1_en) |-> b1_out == $past(a_in));

  // R3
  up_even_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(up1_en) |-> $stable(b1_out));

  // R3
  up_odd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(up2_en) |-> $stable(b2_out));

  // R4
  up_odd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(up2_en) |-> b2_out == $past(a_in));

  // R6
  ret_even_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(sel_even) && $past(dn1_en) |-> a_out == $past(b1_in));

  // R6
  ret_odd_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(sel_even) && $past(dn2_en) |-> a_out == $past(b2_in));

  // R7
  drive_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (a_drive == !$past(a_oe_n) && b1_drive == !$past(b1_oe_n)
               && b2_drive == !$past(b2_oe_n)));
endmodule

bind mbx_exchanger mbx_exchanger_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mbx_exchanger_test.sv
`timescale 1ns/1ps
module mbx_exchanger_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic a_oe_n = 1'b1, b1_oe_n = 1'b1, b2_oe_n = 1'b1;
  logic up1_en = 1'b0, up2_en = 1'b0, dn1_en = 1'b0, dn2_en = 1'b0;
  logic sel_even = 1'b0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drive, b1_drive, b2_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [W-1:0] m_up1, m_up2, m_dn1, m_dn2, m_a;
  logic m_ad, m_b1d, m_b2d;

  always #5 clk = ~clk;

  mbx_exchanger #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive), .a_oe_n(a_oe_n),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drive(b1_drive), .b1_oe_n(b1_oe_n),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drive(b2_drive), .b2_oe_n(b2_oe_n),
    .up1_en(up1_en), .up2_en(up2_en), .dn1_en(dn1_en), .dn2_en(dn2_en),
    .sel_even(sel_even)
  );

  function automatic logic [W-1:0] stage_next(logic en, logic [W-1:0] d, logic [W-1:0] q);
    return en ? d : q;
  endfunction

  function automatic logic [W-1:0] ret_pick(logic s, logic [W-1:0] ev, logic [W-1:0] od);
    return s ? ev : od;
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // inputs are set after a falling edge; model advances as the rising edge would
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_up1 = '0; m_up2 = '0; m_dn1 = '0; m_dn2 = '0; m_a = '0;
      m_ad = 1'b0; m_b1d = 1'b0; m_b2d = 1'b0;
    end else begin
      m_up1 = stage_next(up1_en, a_in, m_up1);
      m_up2 = stage_next(up2_en, a_in, m_up2);
      m_dn1 = stage_next(dn1_en, b1_in, m_dn1);
      m_dn2 = stage_next(dn2_en, b2_in, m_dn2);
      m_a   = ret_pick(sel_even, m_dn1, m_dn2);
      m_ad  = !a_oe_n; m_b1d = !b1_oe_n; m_b2d = !b2_oe_n;
    end
    @(negedge clk);
  endtask

  task automatic check_all();
    chk("R2", "b1_out", b1_out, m_up1);
    chk("R4", "b2_out", b2_out, m_up2);
    chk("R6", "a_out", a_out, m_a);
    chk("R7", "drive", {9'd0, a_drive, b1_drive, b2_drive}, {9'd0, m_ad, m_b1d, m_b2d});
  endtask

  task automatic drive_ctl(logic u1, logic u2, logic d1, logic d2, logic s);
    up1_en = u1; up2_en = u2; dn1_en = d1; dn2_en = d2; sel_even = s;
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    // dirty inputs during reset to see that reset dominates
    a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
    drive_ctl(1, 1, 1, 1, 1);
    a_oe_n = 0; b1_oe_n = 0; b2_oe_n = 0;
    @(negedge clk);
    step(); step();
    // R1: reset state
    chk("R1", "a_out", a_out, '0);
    chk("R1", "b1_out", b1_out, '0);
    chk("R1", "b2_out", b2_out, '0);
    chk("R1", "drive", {9'd0, a_drive, b1_drive, b2_drive}, '0);

    rst = 0;
    // R4: both A-to-bank stages open take the same value
    a_in = 12'h5A5; drive_ctl(1, 1, 0, 0, 1);
    step(); check_all();
    chk("R4", "b1 equals b2", b1_out, b2_out);

    // R3: close even stage, change A; even holds, odd follows
    drive_ctl(0, 1, 0, 0, 1); a_in = 12'h0F0;
    step(); check_all();
    chk("R3", "b1_out held", b1_out, 12'h5A5);
    chk("R4", "b2_out follows", b2_out, 12'h0F0);
    a_in = 12'hFFF; drive_ctl(0, 0, 0, 0, 1);
    step(); step();
    chk("R3", "b1_out still held", b1_out, 12'h5A5);
    chk("R3", "b2_out held", b2_out, 12'h0F0);

    // R5: unselected odd return stage captures while even is shown
    b1_in = 12'h111; b2_in = 12'h222; drive_ctl(0, 0, 1, 1, 1);
    step(); check_all();
    chk("R6", "a_out even", a_out, 12'h111);
    b1_in = 12'h333; b2_in = 12'h444; drive_ctl(0, 0, 0, 0, 1);
    step();
    chk("R5", "a_out even held", a_out, 12'h111);
    // select switch in the same edge as odd stage capturing fresh data
    b2_in = 12'h777; drive_ctl(0, 0, 0, 1, 0);
    step();
    chk("R6", "sel to odd with same-edge capture", a_out, 12'h777);
    // odd drops enable, select flips back to even on the same edge
    b2_in = 12'h999; b1_in = 12'h888; drive_ctl(0, 0, 1, 0, 1);
    step();
    chk("R6", "sel to even with same-edge capture", a_out, 12'h888);
    drive_ctl(0, 0, 0, 0, 0);
    step();
    chk("R5", "odd stage held 777", a_out, 12'h777);

    // R7: bank flags independent
    a_oe_n = 1; b1_oe_n = 0; b2_oe_n = 1;
    step();
    chk("R7", "only even drives", {9'd0, a_drive, b1_drive, b2_drive}, 12'h002);
    a_oe_n = 0; b1_oe_n = 1; b2_oe_n = 0;
    step();
    chk("R7", "A and odd drive", {9'd0, a_drive, b1_drive, b2_drive}, 12'h005);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      a_in  = W'($urandom);
      b1_in = W'($urandom);
      b2_in = W'($urandom);
      drive_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      a_oe_n = 1'($urandom); b1_oe_n = 1'($urandom); b2_oe_n = 1'($urandom);
      step();
      check_all();
    end

    // R1: reset mid-run clears everything
    rst = 1;
    step();
    chk("R1", "a_out after late reset", a_out, '0);
    chk("R1", "b1_out after late reset", b1_out, '0);
    chk("R1", "drive after late reset", {9'd0, a_drive, b1_drive, b2_drive}, '0);
    rst = 0;
    drive_ctl(0, 0, 0, 0, 1);
    step();
    chk("R3", "closed stages stay cleared", b2_out, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule